// File: doc/BRIEF.md
# Branch Target Instruction Buffer

The block is a small fully associative store keyed by branch address. The fetch unit presents every fetch address to the buffer in the same cycle that it presents it to the instruction cache. When the address names a branch the buffer already knows, the buffer returns, in that same cycle, the branch's predicted target address and the instruction word found at that target. The processor can then start executing the target in its normal fetch slot without waiting for the cache.

Branch resolution writes back into the buffer. A branch seen for the first time takes a free slot or, when every slot is in use, the slot whose branch was least recently used across the whole buffer. A resolution that finds a different target from the stored one raises a one-cycle flush request and rewrites the entry. A resolution that agrees with the stored target only refreshes the entry's recency. Two running counters report lookups and hits, so the hit ratio can be measured.

The update port follows valid/ready rules. `upd_ready` is held high at all times, so the buffer never applies back-pressure and each cycle with `upd_valid` high is one accepted resolution. The lookup port is a plain qualified request with no handshake.

Top module: `branch_target_ibuf`

## Requirements
- R1: While `rst` is high at a clock edge, every entry becomes empty. `flush`, `lookup_count` and `hit_count` read zero after that edge.
- R2: Lookup is combinational. `lookup_hit` is high in the cycle that `fetch_addr` matches a stored branch, and that cycle carries the entry's target on `lookup_target` and its word on `lookup_instr`. On a miss, `lookup_hit`, `lookup_target` and `lookup_instr` are all zero.
- R3: An accepted update whose branch is not stored allocates an entry holding branch, target and word. It does not raise `flush`. The branch hits from the next cycle on.
- R4: Allocation uses an empty entry when one exists. Otherwise it evicts the branch whose last use is oldest among all stored branches.
- R5: A use makes a branch the most recent. An accepted update is a use of its branch. A lookup hit is a use only in a cycle with no accepted update; in a cycle with an update, only the update's branch moves.
- R6: An accepted update of a stored branch with a different target raises `flush` for exactly the following cycle. The entry then holds the new target and the new word.
- R7: An accepted update of a stored branch with an equal target leaves `flush` low and leaves the stored word unchanged, even if `upd_instr` differs.
- R8: A lookup and an update of the same branch in the same cycle return the contents from before the update.
- R9: `lookup_count` rises by one after each cycle with `fetch_valid` high. `hit_count` rises by one after each cycle with `lookup_hit` high. Both wrap at their width.
- R10: `upd_ready` is high in every cycle, so no update is ever refused.
- R11: While `fetch_valid` is low, `lookup_hit` is low and no recency changes because of the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch address is present this cycle |
| fetch_addr | input | ADDR_W | Fetch address to look up |
| lookup_hit | output | 1 | Fetch address matches a stored branch |
| lookup_target | output | ADDR_W | Stored target address on a hit, else zero |
| lookup_instr | output | INSTR_W | Stored target instruction on a hit, else zero |
| upd_valid | input | 1 | Branch resolution offered |
| upd_ready | output | 1 | Resolution accepted (always high) |
| upd_branch | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target address |
| upd_instr | input | INSTR_W | Instruction word at the resolved target |
| flush | output | 1 | Pipeline flush request, one cycle per target mismatch |
| lookup_count | output | CNT_W | Number of qualified lookups |
| hit_count | output | CNT_W | Number of lookup hits |

## Verification
The bench runs a four-entry buffer through directed sequences and a long pseudorandom stream drawn from a handful of branch addresses. This keeps evictions, target changes and same-cycle collisions frequent. It predicts every result with a recency-list model of its own.

The sweep is aimed at these failure modes:
- A design with a wrong eviction order loses the wrong branch, and a later lookup misses where a hit is due.
- A design that lets a lookup hit move recency in an update cycle picks the wrong victim later.
- A design that rewrites the word on an equal target returns a changed instruction.
- A design that forwards a same-cycle update returns the new target one cycle early.
- A design that raises `flush` on allocation or on agreement shows a spurious flush pulse.

// File: rtl/btib_pkg.sv
package btib_pkg;

  // Kind of change an accepted resolution makes to the buffer.
  typedef enum logic [1:0] {
    ACT_IDLE,     // no resolution this cycle
    ACT_TOUCH,    // stored target agreed: recency only
    ACT_REWRITE,  // stored target disagreed: rewrite and flush
    ACT_ALLOC     // branch absent: take a slot
  } upd_act_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/btib_match.sv
module btib_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              key,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);

  logic [ENTRIES-1:0] eq;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign eq[gi] = valid[gi] && (tags[gi] == key);
  end

  // Tags are unique, so at most one bit is set; lowest index wins anyway.
  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/btib_lru.sv
module btib_lru #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   victim
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // Rank 0 is most recent, rank ENTRIES-1 least recent; ranks form a permutation.
  logic [ENTRIES-1:0][IDX_W-1:0] rank_q;
  logic [IDX_W-1:0]              touched_rank;

  assign touched_rank = rank_q[touch_idx];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_rank
    always_ff @(posedge clk) begin
      if (rst) begin
        rank_q[gi] <= IDX_W'(gi);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(gi))         rank_q[gi] <= '0;
        else if (rank_q[gi] < touched_rank)  rank_q[gi] <= rank_q[gi] + 1'b1;
      end
    end
  end

  logic               have_free;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   old_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    old_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
      if (rank_q[i] == OLDEST) old_idx = IDX_W'(i);
    end
    victim = have_free ? free_idx : old_idx;
  end

endmodule

// File: rtl/branch_target_ibuf.sv
module branch_target_ibuf #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  output logic               lookup_hit,
  output logic [ADDR_W-1:0]  lookup_target,
  output logic [INSTR_W-1:0] lookup_instr,
  input  logic               upd_valid,
  output logic               upd_ready,
  input  logic [ADDR_W-1:0]  upd_branch,
  input  logic [ADDR_W-1:0]  upd_target,
  input  logic [INSTR_W-1:0] upd_instr,
  output logic               flush,
  output logic [CNT_W-1:0]   lookup_count,
  output logic [CNT_W-1:0]   hit_count
);
  import btib_pkg::*;

  localparam int IDX_W = idx_width(ENTRIES);

  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0]  tag_q;
  logic [ENTRIES-1:0][ADDR_W-1:0]  tgt_q;
  logic [ENTRIES-1:0][INSTR_W-1:0] ins_q;

  logic             l_hit, u_hit;
  logic [IDX_W-1:0] l_idx, u_idx, victim, touch_idx;
  upd_act_e         act;

  btib_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_look_match (
    .valid(valid_q), .tags(tag_q), .key(fetch_addr), .hit(l_hit), .idx(l_idx)
  );

  btib_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_match (
    .valid(valid_q), .tags(tag_q), .key(upd_branch), .hit(u_hit), .idx(u_idx)
  );

  btib_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .touch_en(upd_valid | lookup_hit),
    .touch_idx(touch_idx), .valid(valid_q), .victim(victim)
  );

  assign upd_ready  = 1'b1;
  assign lookup_hit = fetch_valid & l_hit;

  // Contents come straight from registers: a same-cycle update is not forwarded.
  always_comb begin
    lookup_target = lookup_hit ? tgt_q[l_idx] : '0;
    lookup_instr  = lookup_hit ? ins_q[l_idx] : '0;
  end

  always_comb begin
    if (!upd_valid)                    act = ACT_IDLE;
    else if (!u_hit)                   act = ACT_ALLOC;
    else if (tgt_q[u_idx] != upd_target) act = ACT_REWRITE;
    else                               act = ACT_TOUCH;
  end

  // An update owns the recency move; a lookup hit moves only when no update is taken.
  always_comb begin
    if (act == ACT_ALLOC) touch_idx = victim;
    else if (upd_valid)   touch_idx = u_idx;
    else                  touch_idx = l_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q      <= '0;
      tag_q        <= '0;
      tgt_q        <= '0;
      ins_q        <= '0;
      flush        <= 1'b0;
      lookup_count <= '0;
      hit_count    <= '0;
    end else begin
      flush <= 1'b0;
      unique case (act)
        ACT_REWRITE: begin
          tgt_q[u_idx] <= upd_target;
          ins_q[u_idx] <= upd_instr;
          flush        <= 1'b1;
        end
        ACT_ALLOC: begin
          valid_q[victim] <= 1'b1;
          tag_q[victim]   <= upd_branch;
          tgt_q[victim]   <= upd_target;
          ins_q[victim]   <= upd_instr;
        end
        default: ;
      endcase
      if (fetch_valid) lookup_count <= lookup_count + 1'b1;
      if (lookup_hit)  hit_count    <= hit_count + 1'b1;
    end
  end

endmodule

// File: rtl/btib_checker.sv
module btib_checker #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_valid,
  input logic               lookup_hit,
  input logic [ADDR_W-1:0]  lookup_target,
  input logic [INSTR_W-1:0] lookup_instr,
  input logic               upd_valid,
  input logic               flush,
  input logic [CNT_W-1:0]   lookup_count,
  input logic [CNT_W-1:0]   hit_count
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !lookup_hit |-> (lookup_target == '0 && lookup_instr == '0));

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(upd_valid));

  assert_lookup_step_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(fetch_valid)) |-> lookup_count == $past(lookup_count) + 1'b1);

  assert_hit_step_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(lookup_hit)) |-> hit_count == $past(hit_count) + 1'b1);

  assert_idle_fetch_R11: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> !lookup_hit);

endmodule

bind branch_target_ibuf btib_checker #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .CNT_W(CNT_W)
) u_btib_checker (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .lookup_hit(lookup_hit),
  .lookup_target(lookup_target), .lookup_instr(lookup_instr),
  .upd_valid(upd_valid), .flush(flush),
  .lookup_count(lookup_count), .hit_count(hit_count)
);

// File: tb/branch_target_ibuf_bench.sv
module branch_target_ibuf_bench;
  localparam int ENT = 4;
  localparam int AW  = 16;
  localparam int IW  = 16;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic          lookup_hit;
  logic [AW-1:0] lookup_target;
  logic [IW-1:0] lookup_instr;
  logic          upd_valid;
  logic          upd_ready;
  logic [AW-1:0] upd_branch;
  logic [AW-1:0] upd_target;
  logic [IW-1:0] upd_instr;
  logic          flush;
  logic [CW-1:0] lookup_count;
  logic [CW-1:0] hit_count;

  always #2 clk = ~clk;

  branch_target_ibuf #(.ENTRIES(ENT), .ADDR_W(AW), .INSTR_W(IW), .CNT_W(CW)) u_branch_target_ibuf (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .lookup_hit(lookup_hit), .lookup_target(lookup_target), .lookup_instr(lookup_instr),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_branch(upd_branch),
    .upd_target(upd_target), .upd_instr(upd_instr), .flush(flush),
    .lookup_count(lookup_count), .hit_count(hit_count)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Reference model: slots plus a recency list (position 0 = most recent).
  bit            m_valid [ENT];
  logic [AW-1:0] m_tag   [ENT];
  logic [AW-1:0] m_tgt   [ENT];
  logic [IW-1:0] m_ins   [ENT];
  int            order   [ENT];
  bit            m_flush;
  int            m_lc, m_hc;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic touch(input int k);
    int p = 0;
    for (int i = 0; i < ENT; i++) if (order[i] == k) p = i;
    for (int i = p; i > 0; i--) order[i] = order[i-1];
    order[0] = k;
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) begin
      m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ins[i] = '0; order[i] = i;
    end
    m_flush = 0; m_lc = 0; m_hc = 0;
  endtask

  task automatic step(input bit fv, input logic [AW-1:0] fa, input bit uv,
                      input logic [AW-1:0] ua, input logic [AW-1:0] ut, input logic [IW-1:0] ui);
    bit e_hit = 0;
    logic [AW-1:0] e_t = '0;
    logic [IW-1:0] e_i = '0;
    int li = 0;
    int ux = -1;
    @(negedge clk);
    fetch_valid = fv; fetch_addr = fa;
    upd_valid = uv; upd_branch = ua; upd_target = ut; upd_instr = ui;
    #1;
    for (int i = 0; i < ENT; i++)
      if (fv && m_valid[i] && m_tag[i] == fa) begin
        e_hit = 1; e_t = m_tgt[i]; e_i = m_ins[i]; li = i;
      end
    check(lookup_hit == e_hit, "R2 R4 R5 R11 hit", 32'(lookup_hit), 32'(e_hit));
    check(lookup_target == e_t, "R2 R3 R6 R8 target", 32'(lookup_target), 32'(e_t));
    check(lookup_instr == e_i, "R2 R7 R8 instr", 32'(lookup_instr), 32'(e_i));
    check(flush == m_flush, "R3 R6 R7 flush", 32'(flush), 32'(m_flush));
    check(lookup_count == CW'(m_lc), "R9 lookups", 32'(lookup_count), 32'(CW'(m_lc)));
    check(hit_count == CW'(m_hc), "R9 hits", 32'(hit_count), 32'(CW'(m_hc)));
    check(upd_ready == 1'b1, "R10 ready", 32'(upd_ready), 32'd1);
    @(posedge clk);
    m_flush = 0;
    if (uv) begin
      for (int i = 0; i < ENT; i++) if (m_valid[i] && m_tag[i] == ua) ux = i;
      if (ux >= 0) begin
        if (m_tgt[ux] != ut) begin
          m_tgt[ux] = ut; m_ins[ux] = ui; m_flush = 1;
        end
      end else begin
        ux = order[ENT-1];
        for (int i = ENT - 1; i >= 0; i--) if (!m_valid[i]) ux = i;
        m_valid[ux] = 1; m_tag[ux] = ua; m_tgt[ux] = ut; m_ins[ux] = ui;
      end
      touch(ux);
    end else if (e_hit) begin
      touch(li);
    end
    if (fv) m_lc++;
    if (e_hit) m_hc++;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst = 1; fetch_valid = 0; fetch_addr = '0;
    upd_valid = 0; upd_branch = '0; upd_target = '0; upd_instr = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    check(flush == 1'b0, "R1 flush", 32'(flush), 32'd0);
    check(lookup_count == '0, "R1 lookups", 32'(lookup_count), 32'd0);
    check(hit_count == '0, "R1 hits", 32'(hit_count), 32'd0);
    step(1, 16'h0000, 0, '0, '0, '0);
    step(1, 16'h0100, 0, '0, '0, '0);

    // R3 R4: fill four slots, then a fifth branch evicts the least recent
    for (int b = 0; b < ENT; b++)
      step(1, 16'h0100 + 16'(b), 1, 16'h0100 + 16'(b), 16'h2000 + 16'(b), 16'hA000 + 16'(b));
    for (int b = 0; b < ENT; b++) step(1, 16'h0100 + 16'(b), 0, '0, '0, '0);
    step(0, 16'h0101, 1, 16'h0200, 16'h3000, 16'hB000);
    for (int b = 0; b < ENT; b++) step(1, 16'h0100 + 16'(b), 0, '0, '0, '0);
    step(1, 16'h0200, 0, '0, '0, '0);

    // R7: equal target with a new word keeps the old word, no flush
    step(0, '0, 1, 16'h0103, 16'h2003, 16'hFFFF);
    step(1, 16'h0103, 0, '0, '0, '0);

    // R6 R8: mismatch in the same cycle as its own lookup
    step(1, 16'h0103, 1, 16'h0103, 16'h4444, 16'h5555);
    step(1, 16'h0103, 0, '0, '0, '0);
    step(1, 16'h0103, 0, '0, '0, '0);

    // R5: lookup hit in an update cycle does not move recency
    step(1, 16'h0102, 1, 16'h0300, 16'h3100, 16'hB100);
    step(0, '0, 1, 16'h0301, 16'h3200, 16'hB200);
    for (int b = 0; b < ENT; b++) step(1, 16'h0100 + 16'(b), 0, '0, '0, '0);

    // Pseudorandom sweep over a small set of branches and targets
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      step(r[1:0] != 2'b00, 16'h0100 + 16'(r[4:2] % 6),
           r[6:5] == 2'b01, 16'h0100 + 16'(r[9:7] % 6),
           16'h2000 + 16'(r[11:10]), 16'(r[27:12]));
    end
    step(0, '0, 0, '0, '0, '0);
    done = 1;
    summary();
  end

endmodule